// File: doc/BRIEF.md
# Peripheral Clock Power-Down Control

This block keeps one power-down flag for each of four quadrants of eight peripheral selects, 32 flags in all. Software changes them through a small register bus that presents two views of the same state. In the set view, a 1 in a data bit forces that flag to 1. In the clear view, a 1 forces it to 0. In both views a 0 bit leaves the flag alone, and both views read back the current flags. A flag at 1 means the clock of that quadrant is stopped. Each quadrant therefore gets a registered clock-enable output that is high only while its flag is 0.

Only privileged accesses may change the flags. A user-mode write is dropped silently, with no bus error, while reads are open to any mode. A parameter mask lists the quadrants that have a slave behind them. A second mask lists the quadrants that share a bus with the quadrant just below them in the same peripheral select. A shared quadrant owns no flag of its own and follows the flag of its lower neighbour.

Top module: `pclk_pwrdn_ctrl`

## Requirements
- R1: After reset, every flag position that has its own flag reads 1 in both views, every other position reads 0, and every `quad_clk_en` bit is 0.
- R2: A privileged write to the set view at offset 0x80 sets every own-flag bit where the write data holds 1. Data bits at 0 leave their flags unchanged.
- R3: A privileged write to the clear view at offset 0x84 clears every own-flag bit where the write data holds 1. Data bits at 0 leave their flags unchanged.
- R4: A read with `bus_sel`=1 and `bus_wr`=0 at either offset 0x80 or 0x84 returns the same flag word in the same cycle. Bit 4*p+q is quadrant q of peripheral select p.
- R5: A write with `bus_priv`=0 changes no flag, whatever the offset and data.
- R6: Positions without a slave (a 0 in `IMPL_MASK`) and shared positions read 0 and ignore writes. The `quad_clk_en` bit of a position without a slave stays 0.
- R7: A quadrant marked in `SHARE_MASK` (default bits 1 and 5) drives its `quad_clk_en` bit equal to that of the quadrant one position below it.
- R8: For a position with its own flag, `quad_clk_en` equals the inverse of the flag and is registered. After an accepted write the output changes on the next rising edge after the one that updated the flag.
- R9: An access at any other offset, or with `bus_sel`=0, reads 0 and changes no flag.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_sel | input | 1 | Access valid this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_priv | input | 1 | 1 = privileged access |
| bus_addr | input | 12 | Byte offset of the access |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational |
| quad_clk_en | output | 32 | Per-quadrant clock enable, 1 = clock running |

## Verification
Read data is combinational, so the bench samples it one time step after it drives the inputs, in the same cycle. A flag write takes effect at the first rising edge. The matching `quad_clk_en` bit moves at the second rising edge, because the output register samples the flag as it stood before that edge. After each edge the bench compares `quad_clk_en` at the following falling edge with the enables derived from its model's flags as they were before the edge. This way each check lands exactly one register stage after its cause. The stimulus is random bus traffic, with directed sequences for reset, user-mode writes, stray offsets and the shared quadrants.

// File: rtl/pclk_pwrdn_pkg.sv
package pclk_pwrdn_pkg;

   typedef enum logic [1:0] {
      ACC_NONE = 2'd0,
      ACC_SET  = 2'd1,
      ACC_CLR  = 2'd2
   } pwrdn_acc_e;

   // Positions that own a flag: slave present and not folded into a lower quadrant.
   function automatic logic [31:0] own_flags(input logic [31:0] impl, input logic [31:0] share);
      return impl & ~share;
   endfunction

endpackage

// File: rtl/pwrdn_decode.sv
module pwrdn_decode
   import pclk_pwrdn_pkg::*;
#(
   parameter int          ADDR_W  = 12,
   parameter logic [11:0] SET_OFS = 12'h080,
   parameter logic [11:0] CLR_OFS = 12'h084
) (
   input  logic              sel,
   input  logic              wr,
   input  logic              priv,
   input  logic [ADDR_W-1:0] addr,
   output pwrdn_acc_e        wr_acc,
   output logic              rd_hit
);
   localparam logic [ADDR_W-1:0] SET_A = ADDR_W'(SET_OFS);
   localparam logic [ADDR_W-1:0] CLR_A = ADDR_W'(CLR_OFS);

   logic hit_set, hit_clr;

   assign hit_set = (addr == SET_A);
   assign hit_clr = (addr == CLR_A);

   always_comb begin
      wr_acc = ACC_NONE;
      if (sel && wr && priv) begin
         if (hit_set)      wr_acc = ACC_SET;
         else if (hit_clr) wr_acc = ACC_CLR;
      end
   end

   assign rd_hit = sel && !wr && (hit_set || hit_clr);

endmodule

// File: rtl/pwrdn_flag_bank.sv
module pwrdn_flag_bank
   import pclk_pwrdn_pkg::*;
#(
   parameter int          N_FLAGS   = 32,
   parameter logic [31:0] FLAG_MASK = 32'hFFFF_FFFF
) (
   input  logic               clk,
   input  logic               rst_n,
   input  pwrdn_acc_e         wr_acc,
   input  logic [N_FLAGS-1:0] wdata,
   output logic [N_FLAGS-1:0] flags
);
   for (genvar i = 0; i < N_FLAGS; i++) begin : g_bit
      if (FLAG_MASK[i]) begin : g_own
         logic f_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               f_q <= 1'b1;
            end else if (wdata[i]) begin
               if (wr_acc == ACC_SET)      f_q <= 1'b1;
               else if (wr_acc == ACC_CLR) f_q <= 1'b0;
            end
         end
         assign flags[i] = f_q;
      end else begin : g_none
         assign flags[i] = 1'b0;
      end
   end

endmodule

// File: rtl/pwrdn_enable_out.sv
module pwrdn_enable_out #(
   parameter int          N_FLAGS    = 32,
   parameter logic [31:0] IMPL_MASK  = 32'hFFFF_FFFF,
   parameter logic [31:0] SHARE_MASK = 32'h0
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [N_FLAGS-1:0] flags,
   output logic [N_FLAGS-1:0] clk_en
);
   logic [N_FLAGS-1:0] eff_off;

   // Resolve each quadrant to the flag that governs it; lower index first so chains settle.
   always_comb begin
      eff_off[0] = IMPL_MASK[0] ? flags[0] : 1'b1;
      for (int i = 1; i < N_FLAGS; i++) begin
         if (!IMPL_MASK[i])      eff_off[i] = 1'b1;
         else if (SHARE_MASK[i]) eff_off[i] = eff_off[i-1];
         else                    eff_off[i] = flags[i];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) clk_en <= '0;
      else        clk_en <= ~eff_off;
   end

endmodule

// File: rtl/pclk_pwrdn_ctrl.sv
module pclk_pwrdn_ctrl
   import pclk_pwrdn_pkg::*;
#(
   parameter int          NUM_PS     = 8,
   parameter int          NUM_QUAD   = 4,
   parameter int          ADDR_W     = 12,
   parameter logic [11:0] SET_OFS    = 12'h080,
   parameter logic [11:0] CLR_OFS    = 12'h084,
   parameter logic [31:0] IMPL_MASK  = 32'hF0FF_FFFF,
   parameter logic [31:0] SHARE_MASK = 32'h0000_0022
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_sel,
   input  logic              bus_wr,
   input  logic              bus_priv,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [31:0]       bus_wdata,
   output logic [31:0]       bus_rdata,
   output logic [31:0]       quad_clk_en
);
   localparam int          N_FLAGS   = NUM_PS * NUM_QUAD;
   localparam logic [31:0] FLAG_MASK = own_flags(IMPL_MASK, SHARE_MASK);

   function automatic logic share_ok();
      for (int i = 0; i < 32; i++)
         if (SHARE_MASK[i] && ((i % NUM_QUAD) == 0)) return 1'b0;
      return 1'b1;
   endfunction

   if (N_FLAGS != 32) begin : g_chk_width
      $error("pclk_pwrdn_ctrl: NUM_PS*NUM_QUAD must equal the 32-bit register width");
   end
   if ((SHARE_MASK & ~IMPL_MASK) != 32'h0) begin : g_chk_share_impl
      $error("pclk_pwrdn_ctrl: SHARE_MASK may mark only implemented quadrants");
   end
   if (!share_ok()) begin : g_chk_share_q0
      $error("pclk_pwrdn_ctrl: quadrant 0 of a select cannot share with a lower quadrant");
   end
   if (ADDR_W < 8) begin : g_chk_addr
      $error("pclk_pwrdn_ctrl: ADDR_W too narrow for register offsets");
   end

   pwrdn_acc_e  wr_acc;
   logic        rd_hit;
   logic [31:0] flag_q;

   pwrdn_decode #(
      .ADDR_W  (ADDR_W),
      .SET_OFS (SET_OFS),
      .CLR_OFS (CLR_OFS)
   ) u_decode (
      .sel    (bus_sel),
      .wr     (bus_wr),
      .priv   (bus_priv),
      .addr   (bus_addr),
      .wr_acc (wr_acc),
      .rd_hit (rd_hit)
   );

   pwrdn_flag_bank #(
      .N_FLAGS   (32),
      .FLAG_MASK (FLAG_MASK)
   ) u_bank (
      .clk    (clk),
      .rst_n  (rst_n),
      .wr_acc (wr_acc),
      .wdata  (bus_wdata),
      .flags  (flag_q)
   );

   pwrdn_enable_out #(
      .N_FLAGS    (32),
      .IMPL_MASK  (IMPL_MASK),
      .SHARE_MASK (SHARE_MASK)
   ) u_en (
      .clk    (clk),
      .rst_n  (rst_n),
      .flags  (flag_q),
      .clk_en (quad_clk_en)
   );

   assign bus_rdata = rd_hit ? flag_q : 32'h0;

endmodule

// File: rtl/pclk_pwrdn_chk.sv
module pclk_pwrdn_chk #(
   parameter int          ADDR_W     = 12,
   parameter logic [11:0] SET_OFS    = 12'h080,
   parameter logic [11:0] CLR_OFS    = 12'h084,
   parameter logic [31:0] IMPL_MASK  = 32'hF0FF_FFFF,
   parameter logic [31:0] SHARE_MASK = 32'h0000_0022
) (
   input logic              clk,
   input logic              rst_n,
   input logic              bus_sel,
   input logic              bus_wr,
   input logic              bus_priv,
   input logic [ADDR_W-1:0] bus_addr,
   input logic [31:0]       bus_wdata,
   input logic [31:0]       bus_rdata,
   input logic [31:0]       quad_clk_en,
   input logic [31:0]       flags
);
   localparam logic [31:0]       FM    = IMPL_MASK & ~SHARE_MASK;
   localparam logic [ADDR_W-1:0] SET_A = ADDR_W'(SET_OFS);
   localparam logic [ADDR_W-1:0] CLR_A = ADDR_W'(CLR_OFS);

   logic acc_wr;
   assign acc_wr = bus_sel && bus_wr && bus_priv;

   p_set_wr_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (acc_wr && bus_addr == SET_A) |=>
      ((flags & $past(bus_wdata) & FM) == ($past(bus_wdata) & FM)));

   p_clr_wr_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (acc_wr && bus_addr == CLR_A) |=> ((flags & $past(bus_wdata) & FM) == 32'h0));

   p_read_view_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_sel && !bus_wr && (bus_addr == SET_A || bus_addr == CLR_A)) |-> (bus_rdata == flags));

   p_user_keep_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_sel && bus_wr && !bus_priv) |=> $stable(flags));

   p_noslave_off_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (quad_clk_en & ~IMPL_MASK) == 32'h0);

   p_shared_follow_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (quad_clk_en & SHARE_MASK) == ((quad_clk_en << 1) & SHARE_MASK));

   p_en_follow_r8: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> ((quad_clk_en & FM) == (~$past(flags) & FM)));

   p_stray_keep_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !(acc_wr && (bus_addr == SET_A || bus_addr == CLR_A)) |=> $stable(flags));

endmodule

bind pclk_pwrdn_ctrl pclk_pwrdn_chk #(
   .ADDR_W     (ADDR_W),
   .SET_OFS    (SET_OFS),
   .CLR_OFS    (CLR_OFS),
   .IMPL_MASK  (IMPL_MASK),
   .SHARE_MASK (SHARE_MASK)
) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .bus_sel     (bus_sel),
   .bus_wr      (bus_wr),
   .bus_priv    (bus_priv),
   .bus_addr    (bus_addr),
   .bus_wdata   (bus_wdata),
   .bus_rdata   (bus_rdata),
   .quad_clk_en (quad_clk_en),
   .flags       (flag_q)
);

// File: tb/tb_pclk_pwrdn_ctrl.sv
module tb_pclk_pwrdn_ctrl;
   localparam int          CLK_PERIOD = 10;
   localparam logic [31:0] IMPL       = 32'hF0FF_FFFF;
   localparam logic [31:0] SHARE      = 32'h0000_0022;
   localparam logic [31:0] FM         = IMPL & ~SHARE;
   localparam logic [11:0] A_SET      = 12'h080;
   localparam logic [11:0] A_CLR      = 12'h084;
   localparam logic [11:0] A_OTHER    = 12'h088;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_sel = 1'b0, bus_wr = 1'b0, bus_priv = 1'b0;
   logic [11:0] bus_addr = '0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata, quad_clk_en;

   int checks = 0;
   int errors = 0;
   logic [31:0] model;
   bit done = 1'b0;

   pclk_pwrdn_ctrl dut (
      .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
      .bus_priv(bus_priv), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
      .bus_rdata(bus_rdata), .quad_clk_en(quad_clk_en)
   );

   always #(CLK_PERIOD/2) clk = ~clk;

   // Enable expected from a flag word: own flag inverted, shared follows lower, no slave off.
   function automatic logic [31:0] en_of(input logic [31:0] f);
      logic [31:0] e;
      for (int i = 0; i < 32; i++) begin
         if (!IMPL[i])       e[i] = 1'b0;
         else if (SHARE[i])  e[i] = e[i-1];
         else                e[i] = ~f[i];
      end
      return e;
   endfunction

   function automatic logic [31:0] rd_exp(input logic s, input logic w, input logic [11:0] a,
                                          input logic [31:0] m);
      return (s && !w && (a == A_SET || a == A_CLR)) ? m : 32'h0;
   endfunction

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%08h expected=%08h", req, act, exp);
      end
   endtask

   // Called at a falling edge: drive, check read, clock once, check enable.
   task automatic cycle(input logic s, input logic w, input logic p, input logic [11:0] a,
                        input logic [31:0] d, input string req);
      logic [31:0] old;
      bus_sel = s; bus_wr = w; bus_priv = p; bus_addr = a; bus_wdata = d;
      #1;
      if (s && !w) check(req, bus_rdata, rd_exp(s, w, a, model));
      old = model;
      @(posedge clk);
      if (s && w && p) begin
         if (a == A_SET)      model = model | (d & FM);
         else if (a == A_CLR) model = model & ~(d & FM);
      end
      @(negedge clk);
      check("R8 enable", quad_clk_en, en_of(old));
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         errors++;
         $display("FAIL watchdog actual=timeout expected=finish");
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd20240607));
      model = FM;
      repeat (3) @(negedge clk);
      #1;
      check("R1 enables at reset", quad_clk_en, 32'h0);
      rst_n = 1'b1;
      @(negedge clk);
      cycle(1, 0, 0, A_SET, 0, "R1 set view reset");
      cycle(1, 0, 1, A_CLR, 0, "R1 clear view reset");
      check("R1 enables stay off", quad_clk_en, 32'h0);

      // R3: clear all, then check R6 unimplemented read 0
      cycle(1, 1, 1, A_CLR, 32'hFFFF_FFFF, "R3");
      cycle(1, 0, 1, A_SET, 0, "R6 unimplemented read zero");
      cycle(1, 0, 0, A_SET, 0, "R8 settle");
      check("R7 shared quadrant 1", {31'h0, quad_clk_en[1]}, {31'h0, quad_clk_en[0]});
      check("R6 no-slave enables", quad_clk_en & ~IMPL, 32'h0);

      // R2: set some, zero bits leave the rest
      cycle(1, 1, 1, A_SET, 32'h0000_F00F, "R2");
      cycle(1, 1, 1, A_SET, 32'h0, "R2 zero write");
      cycle(1, 0, 0, A_CLR, 0, "R2 readback / R4");
      cycle(1, 0, 0, A_SET, 0, "R4 same word");

      // R5: user-mode writes dropped
      cycle(1, 1, 0, A_CLR, 32'hFFFF_FFFF, "R5");
      cycle(1, 1, 0, A_SET, 32'hFFFF_FFFF, "R5");
      cycle(1, 0, 0, A_SET, 0, "R5 flags kept");

      // R9: stray offset and deselected access
      cycle(1, 1, 1, A_OTHER, 32'hFFFF_FFFF, "R9");
      cycle(0, 1, 1, A_SET, 32'hFFFF_FFFF, "R9");
      cycle(1, 0, 1, A_OTHER, 0, "R9 stray read zero");
      cycle(0, 0, 1, A_SET, 0, "R9 deselected read");
      cycle(1, 0, 1, A_CLR, 0, "R9 flags kept");

      // R7: lower quadrant drives shared one
      cycle(1, 1, 1, A_SET, 32'hFFFF_FFFF, "R2 set all");
      cycle(1, 1, 1, A_CLR, 32'h0000_0001, "R7 clear q0");
      cycle(0, 0, 0, A_SET, 0, "R8 settle");
      check("R7 shared q1 on", quad_clk_en[1:0], 2'b11);
      cycle(1, 1, 1, A_CLR, 32'h0000_0002, "R6 write to shared bit");
      cycle(1, 0, 1, A_SET, 0, "R6 shared bit reads zero");

      for (int k = 0; k < 600; k++) begin
         logic [1:0]  pick;
         logic [11:0] a;
         pick = 2'($urandom_range(0, 3));
         a = (pick == 0) ? A_SET : (pick == 1) ? A_CLR : (pick == 2) ? A_OTHER
             : 12'($urandom_range(0, 4095));
         cycle(($urandom_range(0, 7) != 0), $urandom_range(0, 1) == 1,
               ($urandom_range(0, 3) != 0), a, $urandom(), "R4 random read");
      end

      done = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule